// File: doc/BRIEF.md
# Low-Power Mode Gating Control Register

This block is one 16-bit control register that sits next to a processor core. When the core executes its STOP or WAIT instruction, the block decides whether that instruction is allowed to enter the matching low-power mode. The block turns each allowed instruction into a one-cycle mode-entry request. A disallowed instruction produces no request.

Each mode has a two-bit disable field. One encoding of the field blocks the mode but leaves the field open to software. The other two encodings block the mode and freeze the field until the next device reset. The same register also carries two more bits:
- a software-reset bit, which sends a one-cycle request to the reset controller;
- a debug-clock bit, which chooses between two behaviours for the core's debug clock enable: it follows the TAP enable, or it is forced on.

Software accesses the register over a simple bus. A write takes effect on the clock edge where `reg_sel` and `reg_wr` are both high. `reg_rdata` shows the register contents at all times.

Top module: `lpm_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `reg_rdata` is 0 and `wait_req`, `stop_req` and `swrst_req` are 0. Reset also clears both field locks.
- R2: The WAIT field is bits [1:0] and holds 00 after reset. If `wait_exec` is high at an edge while this field holds 00, `wait_req` is high for the following cycle.
- R3: Writing 01 to a disable field blocks its mode, so the execution strobe produces no request. The field stays writable, so a later write of 00 enables the mode again.
- R4: A write that stores 10 or 11 into an unlocked field also locks that field. While a field is locked, writes do not change its value and its mode stays blocked. Only `rst_n` unlocks the field.
- R5: The STOP field is bits [3:2]. It applies the encodings of R2 to R4 to `stop_exec` and `stop_req`.
- R6: A write while one field is locked still updates the other field and bit 5.
- R7: Writing 1 to bit 4 makes `swrst_req` high for exactly the cycle after the write. Bit 4 always reads 0.
- R8: Bit 5 is stored as written. `dbg_clk_en` equals bit 5 OR `tap_en`.
- R9: Bits [15:6] read 0, and writing to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Device reset, asynchronous, active low |
| reg_sel | input | 1 | Register select for the bus access |
| reg_wr | input | 1 | Write qualifier, sampled together with reg_sel |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current register contents |
| wait_exec | input | 1 | Core executed WAIT this cycle |
| stop_exec | input | 1 | Core executed STOP this cycle |
| tap_en | input | 1 | Core debug TAP enabled |
| wait_req | output | 1 | Request to enter Wait mode |
| stop_req | output | 1 | Request to enter Stop mode |
| swrst_req | output | 1 | Software device reset request |
| dbg_clk_en | output | 1 | Enable for the core debug clock |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is asserted for at least one full clock edge, so the async clear is seen before any property restarts.
- Bus inputs and strobes change only away from the rising edge.

The stimulus keeps to these assumptions by driving every input on the falling edge and by holding reset across two rising edges. Within those limits, the stimulus walks each field through every encoding and fires strobes both with a field blocked and with it enabled. It also tries writes against a locked field.

// File: rtl/lpm_gate_pkg.sv
`timescale 1ns/1ps
package lpm_gate_pkg;
   typedef enum logic [1:0] {
      DIS_NONE     = 2'b00,
      DIS_SOFT     = 2'b01,
      DIS_LOCK     = 2'b10,
      DIS_LOCK_ALT = 2'b11
   } dis_code_e;

   localparam int unsigned FIELD_W   = 2;
   localparam int unsigned N_MODES   = 2;   // index 0 = wait, 1 = stop
   localparam int unsigned WAIT_LSB  = 0;
   localparam int unsigned SWRST_BIT = 4;
   localparam int unsigned DBG_BIT   = 5;
   localparam int unsigned USED_BITS = 6;

   function automatic logic code_locks(input logic [FIELD_W-1:0] code);
      return code[FIELD_W-1];
   endfunction
endpackage

// File: rtl/lpm_mode_field.sv
`timescale 1ns/1ps
module lpm_mode_field
   import lpm_gate_pkg::*;
#(
   parameter bit REQ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_stb,
   input  logic [FIELD_W-1:0] wr_val,
   input  logic               exec_stb,
   output logic [FIELD_W-1:0] field_q,
   output logic               mode_req
);
   logic locked_q;
   logic enter;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_q  <= DIS_NONE;
         locked_q <= 1'b0;
      end else if (wr_stb && !locked_q) begin
         field_q  <= wr_val;
         locked_q <= code_locks(wr_val);
      end
   end

   assign enter = exec_stb && (field_q == DIS_NONE);

   generate
      if (REQ_REG) begin : g_req_reg
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= enter;
         end
         assign mode_req = req_q;

         p_req_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
            mode_req |-> $past(exec_stb && (field_q == DIS_NONE)));
      end else begin : g_req_comb
         assign mode_req = enter;
      end
   endgenerate

   p_write_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !locked_q) |=> (field_q == $past(wr_val)));

   p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> (locked_q && $stable(field_q)));

   p_locked_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |-> (field_q != DIS_NONE));
endmodule

// File: rtl/lpm_aux_ctrl.sv
`timescale 1ns/1ps
module lpm_aux_ctrl #(
   parameter bit DBG_RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   input  logic swrst_wr,
   input  logic dbg_wr,
   input  logic tap_en,
   output logic dbg_q,
   output logic swrst_req,
   output logic dbg_clk_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbg_q     <= DBG_RST_VAL;
         swrst_req <= 1'b0;
      end else begin
         swrst_req <= wr_stb && swrst_wr;
         if (wr_stb) dbg_q <= dbg_wr;
      end
   end

   assign dbg_clk_en = dbg_q | tap_en;

   p_swrst_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      swrst_req |-> $past(wr_stb && swrst_wr));

   p_dbg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_stb) |-> $stable(dbg_q));
endmodule

// File: rtl/lpm_gate_ctrl.sv
`timescale 1ns/1ps
module lpm_gate_ctrl
   import lpm_gate_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter bit          REQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              wait_exec,
   input  logic              stop_exec,
   input  logic              tap_en,
   output logic              wait_req,
   output logic              stop_req,
   output logic              swrst_req,
   output logic              dbg_clk_en
);
   localparam int unsigned HI_W = DATA_W - USED_BITS;

   generate
      if (DATA_W <= USED_BITS) begin : g_bad_width
         $error("lpm_gate_ctrl: DATA_W must exceed %0d", USED_BITS);
      end
   endgenerate

   logic                 wr_stb;
   logic [N_MODES-1:0]   exec_vec;
   logic [N_MODES-1:0]   req_vec;
   logic [FIELD_W-1:0]   field_arr [N_MODES];
   logic                 dbg_q;
   logic                 unused_hi;

   assign wr_stb    = reg_sel && reg_wr;
   assign exec_vec  = {stop_exec, wait_exec};
   assign unused_hi = ^reg_wdata[DATA_W-1:USED_BITS];

   generate
      for (genvar m = 0; m < N_MODES; m++) begin : g_mode
         localparam int unsigned LSB = WAIT_LSB + m * FIELD_W;
         lpm_mode_field #(.REQ_REG(REQ_REG)) u_field (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (wr_stb),
            .wr_val   (reg_wdata[LSB +: FIELD_W]),
            .exec_stb (exec_vec[m]),
            .field_q  (field_arr[m]),
            .mode_req (req_vec[m])
         );
      end
   endgenerate

   assign wait_req = req_vec[0];
   assign stop_req = req_vec[1];

   lpm_aux_ctrl u_aux (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb     (wr_stb),
      .swrst_wr   (reg_wdata[SWRST_BIT]),
      .dbg_wr     (reg_wdata[DBG_BIT]),
      .tap_en     (tap_en),
      .dbg_q      (dbg_q),
      .swrst_req  (swrst_req),
      .dbg_clk_en (dbg_clk_en)
   );

   always_comb begin
      reg_rdata = '0;
      for (int m = 0; m < N_MODES; m++) begin
         reg_rdata[WAIT_LSB + m * FIELD_W +: FIELD_W] = field_arr[m];
      end
      reg_rdata[DBG_BIT] = dbg_q;
   end

   p_hi_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1 -: HI_W] == '0);
endmodule

// File: tb/tb_lpm_gate_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_gate_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0, reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        wait_exec = 1'b0, stop_exec = 1'b0, tap_en = 1'b0;
   logic        wait_req, stop_req, swrst_req, dbg_clk_en;

   always #2.5 clk = ~clk;

   lpm_gate_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .wait_exec(wait_exec), .stop_exec(stop_exec), .tap_en(tap_en),
      .wait_req(wait_req), .stop_req(stop_req), .swrst_req(swrst_req),
      .dbg_clk_en(dbg_clk_en)
   );

   typedef struct {
      logic        wq, sq, rq, dbg;
      logic [15:0] rd;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0, n_fail = 0;
   bit   done = 0;

   // reference model state
   logic [1:0] m_w = 2'b00, m_s = 2'b00;
   logic       lk_w = 0, lk_s = 0, m_dbg = 0;

   task automatic cyc(input logic s, input logic w, input logic [15:0] d,
                      input logic ws, input logic ss, input logic tp, input string tag);
      exp_t e;
      @(negedge clk);
      reg_sel = s; reg_wr = w; reg_wdata = d;
      wait_exec = ws; stop_exec = ss; tap_en = tp;
      e.wq = ws && (m_w == 2'b00);
      e.sq = ss && (m_s == 2'b00);
      e.rq = s && w && d[4];
      if (s && w) begin
         if (!lk_w) begin m_w = d[1:0]; lk_w = d[1]; end
         if (!lk_s) begin m_s = d[3:2]; lk_s = d[3]; end
         m_dbg = d[5];
      end
      e.rd  = {10'b0, m_dbg, 1'b0, m_s, m_w};
      e.dbg = m_dbg | tp;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wr(input logic [15:0] d, input string tag);
      cyc(1'b1, 1'b1, d, 1'b0, 1'b0, 1'b0, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; reg_sel = 0; reg_wr = 0; reg_wdata = '0;
      wait_exec = 1; stop_exec = 1; tap_en = 0;
      m_w = 0; m_s = 0; lk_w = 0; lk_s = 0; m_dbg = 0;
      repeat (2) @(negedge clk);
      n_chk++;
      if (reg_rdata !== 16'h0 || wait_req !== 0 || stop_req !== 0 || swrst_req !== 0) begin
         n_fail++;
         $display("FAIL R1: rdata=%h reqs=%b%b%b expected 0000 000",
                  reg_rdata, wait_req, stop_req, swrst_req);
      end
      rst_n = 1; wait_exec = 0; stop_exec = 0;
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (wait_req !== e.wq || stop_req !== e.sq || swrst_req !== e.rq ||
                reg_rdata !== e.rd || dbg_clk_en !== e.dbg) begin
               n_fail++;
               $display("FAIL %s: w/s/r=%b%b%b rd=%h dbg=%b expected w/s/r=%b%b%b rd=%h dbg=%b",
                        e.tag, wait_req, stop_req, swrst_req, reg_rdata, dbg_clk_en,
                        e.wq, e.sq, e.rq, e.rd, e.dbg);
            end
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();                                           // R1
      cyc(0, 0, 16'h0, 1, 0, 0, "R2");
      cyc(0, 0, 16'h0, 0, 1, 0, "R5");
      cyc(0, 0, 16'h0, 1, 1, 0, "R2");
      wr(16'h0001, "R3");
      cyc(0, 0, 16'h0, 1, 0, 0, "R3");
      wr(16'h0000, "R3");
      cyc(0, 0, 16'h0, 1, 0, 0, "R3");
      wr(16'h0004, "R5");
      cyc(0, 0, 16'h0, 0, 1, 0, "R5");
      wr(16'h0000, "R5");
      cyc(0, 0, 16'h0, 0, 1, 0, "R5");
      cyc(1, 0, 16'h0001, 1, 0, 0, "R2");                   // read access, no write
      wr(16'h0002, "R4");
      wr(16'h0000, "R4");
      cyc(0, 0, 16'h0, 1, 0, 0, "R4");
      wr(16'h0004, "R6");
      wr(16'h0001, "R6");
      cyc(0, 0, 16'h0, 1, 1, 0, "R6");
      wr(16'h0010, "R7");
      cyc(0, 0, 16'h0, 0, 0, 0, "R7");
      wr(16'h0010, "R7");
      wr(16'h0010, "R7");
      cyc(0, 0, 16'h0, 0, 0, 0, "R8");
      wr(16'h0020, "R8");
      cyc(0, 0, 16'h0, 0, 0, 1, "R8");
      wr(16'h0000, "R8");
      cyc(0, 0, 16'h0, 0, 0, 1, "R8");
      cyc(0, 0, 16'h0, 0, 0, 0, "R8");
      wr(16'hFFC0, "R9");
      wr(16'hFFEC, "R9");
      cyc(0, 0, 16'h0, 0, 1, 0, "R4");
      wr(16'h0000, "R4");
      do_reset();                                           // R1, locks cleared
      cyc(0, 0, 16'h0, 1, 1, 0, "R4");
      wr(16'h0001, "R4");
      wr(16'h0000, "R4");
      cyc(0, 0, 16'h0, 1, 1, 0, "R4");
      wr(16'h000C, "R5");
      wr(16'h0003, "R5");
      cyc(0, 0, 16'h0, 1, 1, 0, "R5");
      cyc(0, 0, 16'h0, 0, 0, 0, "R5");
      repeat (3) @(posedge clk);
      #2;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule